// File: doc/BRIEF.md
# Transfer Packet Busy Flags and Channel Abort

This block keeps one busy flag for each of four transfer control packets. The packets belong to two transfer channels, and each channel has an A packet and a B packet. A frame sequencer pulses a frame-start input for a packet when a frame actually begins on it. That can be some cycles after the transfer was requested. The sequencer pulses a frame-end input when the frame completes. Each flag therefore shows whether a frame is in flight on its packet. After software stops a packet or switches buffers, it polls the flag to learn when the buffer is safe to read.

All four flags are visible in one 32-bit status word on a simple register bus. Each flag sits in the lowest bit of its own byte lane.

A write of 1 to a set flag is an abort, and it must come with the privilege qualifier. The abort clears the flag and acts on the whole channel:
- the channel's element counter gets a one-cycle clear pulse;
- the channel's enable bit gets a one-cycle clear pulse;
- new element transfers are held off by an inhibit level until the channel is enabled again.

Top module: `pkt_busy_ctrl`

## Requirements
- R1: After reset, every busy flag, counter-clear pulse, enable-clear pulse and transfer inhibit is 0.
- R2: A read of the status address returns the flags at these bit positions: channel 0 packet A at bit 24, channel 0 packet B at bit 16, channel 1 packet A at bit 8, channel 1 packet B at bit 0. Every other bit reads 0. A read of any other address, or any write cycle, returns 0 on the read data.
- R3: A frame-start pulse on a packet sets its flag on the next clock edge.
- R4: A frame-end pulse on a packet clears its flag on the next clock edge.
- R5: When frame-start and frame-end arrive on the same packet in the same cycle, the flag ends set.
- R6: A privileged write to the status address clears, on the next edge, exactly those flags that are set and whose data bit is 1. Flags written with 0 keep their value.
- R7: A write without the privilege qualifier changes no flag and produces no abort output.
- R8: Writing 1 to a flag that is 0 has no effect and produces no abort output for its channel.
- R9: A clearing write makes the channel's counter-clear and enable-clear outputs high for exactly the one cycle after the write edge. From that same edge the channel's transfer inhibit is high.
- R10: A channel's transfer inhibit stays high until a channel-enable pulse and drops on the edge after it. When an abort and an enable arrive in the same cycle, the abort wins and the inhibit stays high.
- R11: When a clearing write and a frame-start hit the same packet in the same cycle, the flag ends cleared.
- R12: A write of 1 to both packets of one channel, with both flags set, gives one single counter-clear and enable-clear pulse for that channel.
- R13: Writes to reserved bit positions have no effect on any flag or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| frame_start | input | 4 | Per-packet frame start pulse, index ch*2+pkt (pkt 0 = A) |
| frame_end | input | 4 | Per-packet frame end pulse, same indexing |
| chan_enable | input | 2 | Per-channel pulse: channel enabled again |
| busy | output | 4 | Busy flags, same indexing as frame_start |
| cnt_clr | output | 2 | Per-channel element counter clear pulse |
| en_clr | output | 2 | Per-channel enable bit clear pulse |
| xfer_inhibit | output | 2 | Per-channel level: block new element transfers |

## Verification
The bench builds the block with its defaults: two channels, an 8-bit address and the status word at 0x10. With these values the whole 32-bit map, both A/B pairs and both channel abort paths can be reached.

Random addresses are drawn from only two values, the status address and one decoy. Privilege, write data and frame pulses are random, so decoded writes, same-cycle start/end/clear collisions and aborts on one or both packets of a channel all occur often in a few thousand cycles. Directed cases first pin down the bit map, the ignored writes and the priority rules.

// File: rtl/pkt_busy_pkg.sv
package pkt_busy_pkg;

  localparam int unsigned LANE_W     = 8;
  localparam int unsigned PKT_PER_CH = 2;
  localparam int unsigned REG_W      = 32;

  typedef enum logic {
    PKT_A = 1'b0,
    PKT_B = 1'b1
  } pkt_side_e;

  // Flat packet index p = ch*PKT_PER_CH + side; packet 0 occupies the top lane.
  function automatic int unsigned flag_pos(input int unsigned p, input int unsigned npkt);
    return LANE_W * (npkt - 1 - p);
  endfunction

endpackage

// File: rtl/busy_reg_port.sv
module busy_reg_port
  import pkt_busy_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned REG_ADDR = 'h10,
  parameter int unsigned NPKT     = 4
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_priv,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPKT-1:0]   wr_bits,
  input  logic [NPKT-1:0]   busy_q,
  output logic [NPKT-1:0]   clr_req,
  output logic [REG_W-1:0]  rdata
);

  logic addr_hit;
  logic wr_ok;
  logic rd_ok;

  always_comb begin
    addr_hit = (bus_addr == ADDR_W'(REG_ADDR));
    wr_ok    = bus_sel && bus_wr && bus_priv && addr_hit;
    rd_ok    = bus_sel && !bus_wr && addr_hit;
  end

  always_comb begin
    rdata = '0;
    for (int unsigned p = 0; p < NPKT; p++) begin
      clr_req[p] = wr_ok && wr_bits[p] && busy_q[p];
      if (rd_ok) rdata[flag_pos(p, NPKT)] = busy_q[p];
    end
  end

endmodule

// File: rtl/busy_flag.sv
module busy_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic end_i,
  input  logic clr_i,
  output logic busy_q
);

  logic busy_nx;
  logic busy_en;

  always_comb begin
    busy_en = clr_i || start_i || end_i;
    if (clr_i)        busy_nx = 1'b0;
    else if (start_i) busy_nx = 1'b1;
    else              busy_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (busy_en) busy_q <= busy_nx;
  end

  p_clr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !busy_q);
  p_start_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !clr_i) |=> busy_q);
  p_end_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && !start_i && !clr_i) |=> !busy_q);
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !end_i && !clr_i) |=> $stable(busy_q));

endmodule

// File: rtl/chan_abort.sv
module chan_abort (
  input  logic clk,
  input  logic rst_n,
  input  logic abort_i,
  input  logic enable_i,
  output logic cnt_clr_q,
  output logic en_clr_q,
  output logic inhibit_q
);

  logic inhibit_nx;
  logic inhibit_en;

  always_comb begin
    inhibit_en = abort_i || enable_i;
    inhibit_nx = abort_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_clr_q <= 1'b0;
      en_clr_q  <= 1'b0;
      inhibit_q <= 1'b0;
    end else begin
      cnt_clr_q <= abort_i;
      en_clr_q  <= abort_i;
      if (inhibit_en) inhibit_q <= inhibit_nx;
    end
  end

  p_abort_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (cnt_clr_q && en_clr_q && inhibit_q));
  p_pulse_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_i |=> (!cnt_clr_q && !en_clr_q));
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !abort_i) |=> !inhibit_q);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_q && !enable_i) |=> inhibit_q);

endmodule

// File: rtl/pkt_busy_ctrl.sv
module pkt_busy_ctrl
  import pkt_busy_pkg::*;
#(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned REG_ADDR = 'h10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_sel,
  input  logic                         bus_wr,
  input  logic                         bus_priv,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  input  logic [NUM_CH*PKT_PER_CH-1:0] frame_start,
  input  logic [NUM_CH*PKT_PER_CH-1:0] frame_end,
  input  logic [NUM_CH-1:0]            chan_enable,
  output logic [NUM_CH*PKT_PER_CH-1:0] busy,
  output logic [NUM_CH-1:0]            cnt_clr,
  output logic [NUM_CH-1:0]            en_clr,
  output logic [NUM_CH-1:0]            xfer_inhibit
);

  localparam int unsigned NPKT = NUM_CH * PKT_PER_CH;

  function automatic logic [31:0] flag_mask();
    logic [31:0] m;
    m = '0;
    for (int unsigned p = 0; p < NPKT; p++) m[flag_pos(p, NPKT)] = 1'b1;
    return m;
  endfunction

  localparam logic [31:0] FLAG_MASK = flag_mask();

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_sync_q1;
  logic rst_sync_q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q1 <= 1'b0;
      rst_sync_q2 <= 1'b0;
    end else begin
      rst_sync_q1 <= 1'b1;
      rst_sync_q2 <= rst_sync_q1;
    end
  end

  logic rst_n_s;
  assign rst_n_s = rst_sync_q2;

  logic [NPKT-1:0]   wr_bits;
  logic [NPKT-1:0]   clr_req;
  logic [NUM_CH-1:0] abort_req;
  logic              unused_wdata;

  always_comb begin
    for (int unsigned p = 0; p < NPKT; p++) wr_bits[p] = bus_wdata[flag_pos(p, NPKT)];
    unused_wdata = ^(bus_wdata & ~FLAG_MASK);
  end

  busy_reg_port #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR),
    .NPKT    (NPKT)
  ) i_reg_port (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_priv(bus_priv),
    .bus_addr(bus_addr),
    .wr_bits (wr_bits),
    .busy_q  (busy),
    .clr_req (clr_req),
    .rdata   (bus_rdata)
  );

  for (genvar gp = 0; gp < NPKT; gp++) begin : g_flag
    busy_flag i_flag (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .start_i(frame_start[gp]),
      .end_i  (frame_end[gp]),
      .clr_i  (clr_req[gp]),
      .busy_q (busy[gp])
    );
  end

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chan
    always_comb abort_req[gc] = |clr_req[gc*PKT_PER_CH +: PKT_PER_CH];

    chan_abort i_abort (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .abort_i  (abort_req[gc]),
      .enable_i (chan_enable[gc]),
      .cnt_clr_q(cnt_clr[gc]),
      .en_clr_q (en_clr[gc]),
      .inhibit_q(xfer_inhibit[gc])
    );
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_rdata & ~FLAG_MASK) == 32'd0);
  p_nopriv_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(bus_sel && bus_wr && bus_priv) |=> (en_clr == '0 && cnt_clr == '0));
  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy == '0) |=> (en_clr == '0));
  p_reset_r1: assert property (@(posedge clk)
    !rst_n_s |-> (busy == '0 && xfer_inhibit == '0 && en_clr == '0));

endmodule

// File: tb/test_pkt_busy_ctrl.sv
module test_pkt_busy_ctrl;

  localparam logic [7:0] REG = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, wr, priv;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [3:0]  fs, fe, busy;
  logic [1:0]  ena, cnt_clr, en_clr, inh;

  logic [3:0]  mb;
  logic [1:0]  mi, mp;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  pkt_busy_ctrl i_pkt_busy_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_priv(priv),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .frame_start(fs), .frame_end(fe), .chan_enable(ena),
    .busy(busy), .cnt_clr(cnt_clr), .en_clr(en_clr), .xfer_inhibit(inh)
  );

  // R2 map: packet p (ch*2+side) at bit 8*(3-p)
  function automatic logic [31:0] pack(input logic [3:0] b);
    logic [31:0] r = '0;
    for (int p = 0; p < 4; p++) r[8*(3-p)] = b[p];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sel = 0; wr = 0; priv = 0; addr = 8'h00; wdata = '0; fs = '0; fe = '0; ena = '0;
  endtask

  task automatic bus_write(input logic pv, input logic [31:0] d);
    sel = 1; wr = 1; priv = pv; addr = REG; wdata = d;
  endtask

  // Called just after a falling edge with inputs already driven.
  task automatic step(input string tag);
    logic [3:0] clrv, nb;
    logic [1:0] ab;
    #1;
    chk({tag, " rdata R2"}, rdata, (sel && !wr && addr == REG) ? pack(mb) : 32'd0);
    for (int p = 0; p < 4; p++)
      clrv[p] = sel && wr && priv && addr == REG && wdata[8*(3-p)] && mb[p];
    for (int p = 0; p < 4; p++)
      nb[p] = clrv[p] ? 1'b0 : fs[p] ? 1'b1 : fe[p] ? 1'b0 : mb[p];
    for (int c = 0; c < 2; c++) begin
      ab[c] = clrv[2*c] | clrv[2*c+1];
      mi[c] = ab[c] ? 1'b1 : ena[c] ? 1'b0 : mi[c];
    end
    mp = ab;
    mb = nb;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " busy"},    {28'd0, busy},    {28'd0, mb});
    chk({tag, " cnt_clr"}, {30'd0, cnt_clr}, {30'd0, mp});
    chk({tag, " en_clr"},  {30'd0, en_clr},  {30'd0, mp});
    chk({tag, " inhibit"}, {30'd0, inh},     {30'd0, mi});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    idle();
    mb = '0; mi = '0; mp = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) step("R1 reset");
    chk("R1 outputs", {22'd0, busy, cnt_clr, en_clr, inh}, 32'd0);

    fs = 4'b0001; step("R3 set ch0A");
    idle(); sel = 1; addr = REG; step("R2 read ch0A");
    fs = 4'b1110; step("R3 set rest");
    idle(); sel = 1; addr = REG; step("R2 read all");
    sel = 1; addr = 8'h14; step("R2 other addr");
    idle(); bus_write(1'b0, 32'hFFFF_FFFF); step("R7 nonpriv");
    idle(); bus_write(1'b1, 32'hFEFE_FEFE); step("R13 reserved");
    idle(); fe = 4'b1000; step("R4 end ch1B");
    idle(); bus_write(1'b1, 32'h0000_0001); step("R8 zero flag");
    idle(); fe = 4'b0100; fs = 4'b0100; step("R5 start+end");
    idle(); bus_write(1'b1, 32'h0100_0000); step("R9 abort ch0A");
    idle(); step("R9 pulse ends");
    ena = 2'b01; bus_write(1'b1, 32'h0001_0000); step("R10 abort beats enable");
    idle(); ena = 2'b01; step("R10 release");
    idle(); fs = 4'b0001; step("R3 reset ch0A");
    idle(); bus_write(1'b1, 32'h0100_0000); fs = 4'b0001; step("R11 clear beats start");
    idle(); fs = 4'b1100; step("R3 set ch1");
    idle(); bus_write(1'b1, 32'h0000_0101); step("R12 dual abort");
    idle(); bus_write(1'b1, 32'h0000_0001); fs = 4'b0010; step("R6 keep others");
    idle(); ena = 2'b11; step("R10 release both");

    for (int i = 0; i < 4000; i++) begin
      sel   = ($urandom % 4) != 0;
      wr    = $urandom % 2;
      priv  = ($urandom % 4) != 0;
      addr  = ($urandom % 3 != 0) ? REG : 8'h14;
      wdata = $urandom;
      fs    = $urandom & $urandom;
      fe    = $urandom & $urandom;
      ena   = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      step("RND R6");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule